// File: doc/BRIEF.md
# March Pattern Sequencer for Memory Self-Test

This block is the stimulus side of a memory self-test. After a start pulse it drives a synchronous single-port RAM with a fixed series of write and read operations, one operation per clock. Each operation comes from one of two March-style algorithms. Mode 0 is a short test aimed at address-decoder faults. Mode 1 is a longer linked-fault test of the storage cells, repeated once for each word data background. On every read it also produces the word that the RAM should return, delayed by the RAM's read latency, so that a comparator placed elsewhere can check the response. A one-cycle done pulse marks the end of the run.

The address width, the data width and the read latency (1 or 2 cycles) are parameters. The number of addressable words is N = 2^ADDR_W.

For a word-wide memory the cell test runs once for each of several backgrounds. Background 0 is all zeros. Background k (k ≥ 1) sets bit i of the word to bit (k−1) of the index i. This gives alternating single bits, then alternating pairs, and so on, up to the pattern whose upper half is ones. When the algorithm writes or reads a logical 1, the word used is the complement of the current background. When the memory is one bit wide, only background 0 is used.

Top module: `march_tgen`

## Requirements
- R1: With mode=0 the run is exactly 5N operations in three passes: ascending addresses write 0; ascending addresses read 0 then write 1; descending addresses read 1 then write 0. Logical 0 is the all-zeros word and logical 1 is the all-ones word.
- R2: With mode=1 each background runs 16N operations in six passes. The passes are: ascending w0; descending (r0,w1); ascending (r1,w0,r0,r0,w1); ascending (r1,w0); ascending (r0,w1,r1,r1,w0); ascending r0.
- R3: In mode=1 the number of backgrounds is 1+clog2(DATA_W), or 1 when DATA_W=1. Backgrounds run in order k=0,1,... and use the bit rule given above. Logical 1 is the bitwise complement of the background.
- R4: exp_valid is high exactly RD_LAT cycles after a cycle with mem_re high. In that cycle exp_data holds the word the read should return. When exp_valid is low, exp_data is zero.
- R5: done is high for exactly one cycle, RD_LAT+1 cycles after the last operation. After that, all outputs stay zero until the next start.
- R6: A start pulse that arrives while a run is in progress is ignored, whatever the value of mode. The run continues unchanged.
- R7: During reset and after reset, every output is zero.
- R8: mem_we and mem_re are never both high. Exactly one of them is high in every cycle of a run.
- R9: The first operation is issued in the cycle after start is sampled. In a descending pass the address goes from N−1 down to 0. mem_wdata is zero on read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| mode | input | 1 | 0 = decoder test, 1 = cell test with backgrounds |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | DATA_W | Write data |
| exp_data | output | DATA_W | Expected read data |
| exp_valid | output | 1 | Expected data is due this cycle |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The decoder test and the cell test are each run on an 8-bit, 1-cycle-latency instance and on a 1-bit, 2-cycle-latency instance. The first separates the background stepping and complement rules. The second checks that backgrounds are skipped and that the expected-data delay follows the latency parameter. In selected runs a start pulse with the opposite mode is injected partway through, to show that it neither restarts the run nor switches the algorithm. Every cycle of every run is compared against an operation list that the bench builds from pass descriptions, which exposes wrong directions, wrong operation order within a pass, and off-by-one errors in the done timing.

// File: rtl/march_pkg.sv
package march_pkg;
   typedef enum logic {ALG_DEC = 1'b0, ALG_CELL = 1'b1} alg_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DRAIN = 2'd2} seq_st_e;

   // operation code {is_write, logical value}
   localparam logic [1:0] OP_R0 = 2'b00;
   localparam logic [1:0] OP_R1 = 2'b01;
   localparam logic [1:0] OP_W0 = 2'b10;
   localparam logic [1:0] OP_W1 = 2'b11;

   function automatic logic [2:0] pass_count(alg_e a);
      return (a == ALG_DEC) ? 3'd3 : 3'd6;
   endfunction

   function automatic logic [2:0] pass_len(alg_e a, logic [2:0] e);
      logic [2:0] n;
      if (a == ALG_DEC) n = (e == 3'd0) ? 3'd1 : 3'd2;
      else begin
         case (e)
            3'd0, 3'd5: n = 3'd1;
            3'd1, 3'd3: n = 3'd2;
            default:    n = 3'd5;
         endcase
      end
      return n;
   endfunction

   function automatic logic pass_down(alg_e a, logic [2:0] e);
      return (a == ALG_DEC) ? (e == 3'd2) : (e == 3'd1);
   endfunction

   function automatic logic [1:0] pass_op(alg_e a, logic [2:0] e, logic [2:0] k);
      logic [1:0] r;
      r = OP_R0;
      if (a == ALG_DEC) begin
         case (e)
            3'd0:    r = OP_W0;
            3'd1:    r = (k == 3'd0) ? OP_R0 : OP_W1;
            default: r = (k == 3'd0) ? OP_R1 : OP_W0;
         endcase
      end else begin
         case (e)
            3'd0: r = OP_W0;
            3'd1: r = (k == 3'd0) ? OP_R0 : OP_W1;
            3'd2: begin
               case (k)
                  3'd0:       r = OP_R1;
                  3'd1:       r = OP_W0;
                  3'd2, 3'd3: r = OP_R0;
                  default:    r = OP_W1;
               endcase
            end
            3'd3: r = (k == 3'd0) ? OP_R1 : OP_W0;
            3'd4: begin
               case (k)
                  3'd0:       r = OP_R0;
                  3'd1:       r = OP_W1;
                  3'd2, 3'd3: r = OP_R1;
                  default:    r = OP_W0;
               endcase
            end
            default: r = OP_R0;
         endcase
      end
      return r;
   endfunction
endpackage

// File: rtl/march_bg_gen.sv
module march_bg_gen #(
   parameter int DATA_W = 8,
   parameter int BG_W   = 2
) (
   input  logic [BG_W-1:0]   bg_idx,
   output logic [DATA_W-1:0] pattern
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      always_comb begin
         if (bg_idx == '0) pattern[i] = 1'b0;
         else              pattern[i] = ((i >> (int'(bg_idx) - 1)) & 1) != 0;
      end
   end
endmodule

// File: rtl/march_rd_pipe.sv
module march_rd_pipe #(
   parameter int DATA_W = 8,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_dat,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_dat
);
   logic              vld [RD_LAT];
   logic [DATA_W-1:0] dat [RD_LAT];

   for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      logic              nv;
      logic [DATA_W-1:0] nd;
      if (s == 0) begin : g_head
         assign nv = in_vld;
         assign nd = in_vld ? in_dat : '0;
      end else begin : g_tail
         assign nv = vld[s-1];
         assign nd = dat[s-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[s] <= 1'b0;
            dat[s] <= '0;
         end else begin
            vld[s] <= nv;
            dat[s] <= nd;
         end
      end
   end

   assign out_vld = vld[RD_LAT-1];
   assign out_dat = dat[RD_LAT-1];
endmodule

// File: rtl/march_seq.sv
module march_seq
   import march_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NUM_BG = 4,
   parameter int BG_W   = 2,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode,
   output logic              running,
   output logic [ADDR_W-1:0] addr,
   output logic              op_wr,
   output logic              op_rd,
   output logic              op_val,
   output logic [BG_W-1:0]   bg_idx,
   output logic              fin
);
   seq_st_e           st;
   alg_e              alg;
   logic [2:0]        pass_q, op_q;
   logic [ADDR_W-1:0] cnt;
   logic              dcnt;
   logic [1:0]        code;
   logic              last_op, last_addr, last_pass, last_bg;

   always_comb begin
      code      = pass_op(alg, pass_q, op_q);
      last_op   = (op_q == pass_len(alg, pass_q) - 3'd1);
      last_addr = &cnt;
      last_pass = (pass_q == pass_count(alg) - 3'd1);
      last_bg   = (alg == ALG_DEC) || (bg_idx == BG_W'(NUM_BG - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         alg    <= ALG_DEC;
         pass_q <= '0;
         op_q   <= '0;
         cnt    <= '0;
         bg_idx <= '0;
         dcnt   <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_RUN;
                  alg    <= alg_e'(mode);
                  pass_q <= '0;
                  op_q   <= '0;
                  cnt    <= '0;
                  bg_idx <= '0;
               end
            end
            ST_RUN: begin
               if (!last_op) op_q <= op_q + 3'd1;
               else begin
                  op_q <= '0;
                  if (!last_addr) cnt <= cnt + 1'b1;
                  else begin
                     cnt <= '0;
                     if (!last_pass) pass_q <= pass_q + 3'd1;
                     else begin
                        pass_q <= '0;
                        if (last_bg) begin
                           st   <= ST_DRAIN;
                           dcnt <= 1'(RD_LAT - 1);
                        end else bg_idx <= bg_idx + 1'b1;
                     end
                  end
               end
            end
            ST_DRAIN: begin
               if (dcnt == 1'b0) begin
                  st  <= ST_IDLE;
                  fin <= 1'b1;
               end else dcnt <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign running = (st == ST_RUN);
   assign op_wr   = running && code[1];
   assign op_rd   = running && !code[1];
   assign op_val  = code[0];
   assign addr    = !running ? '0 : (pass_down(alg, pass_q) ? ~cnt : cnt);
endmodule

// File: rtl/march_tgen.sv
module march_tgen #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] exp_data,
   output logic              exp_valid,
   output logic              done
);
   localparam int NUM_BG = (DATA_W == 1) ? 1 : $clog2(DATA_W) + 1;
   localparam int BG_W   = (NUM_BG > 1) ? $clog2(NUM_BG) : 1;

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_aw
      $error("march_tgen: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("march_tgen: DATA_W must be positive");
   end
   if (RD_LAT < 1 || RD_LAT > 2) begin : g_bad_lat
      $error("march_tgen: RD_LAT must be 1 or 2");
   end

   logic              running, op_wr, op_rd, op_val;
   logic [BG_W-1:0]   bg_idx;
   logic [DATA_W-1:0] pattern, word;

   march_seq #(.ADDR_W(ADDR_W), .NUM_BG(NUM_BG), .BG_W(BG_W), .RD_LAT(RD_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .running(running), .addr(mem_addr), .op_wr(op_wr), .op_rd(op_rd),
      .op_val(op_val), .bg_idx(bg_idx), .fin(done)
   );

   march_bg_gen #(.DATA_W(DATA_W), .BG_W(BG_W)) u_bg (
      .bg_idx(bg_idx), .pattern(pattern)
   );

   assign word      = op_val ? ~pattern : pattern;
   assign mem_we    = op_wr;
   assign mem_re    = op_rd;
   assign mem_wdata = op_wr ? word : '0;

   march_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .in_vld(op_rd), .in_dat(word),
      .out_vld(exp_valid), .out_dat(exp_data)
   );
endmodule

// File: rtl/march_tgen_chk.sv
module march_tgen_chk #(
   parameter int RD_LAT = 1
) (
   input logic clk,
   input logic rst_n,
   input logic mem_we,
   input logic mem_re,
   input logic exp_valid,
   input logic done,
   input logic running
);
   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (mem_we || mem_re));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_we && !mem_re && !running));

   if (RD_LAT == 1) begin : g_l1
      assert_strobe_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
         exp_valid == $past(mem_re));
   end else begin : g_l2
      assert_strobe_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
         exp_valid == $past(mem_re, 2));
   end
endmodule

bind march_tgen march_tgen_chk #(.RD_LAT(RD_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re),
   .exp_valid(exp_valid), .done(done), .running(running)
);

// File: tb/march_tgen_bench.sv
`timescale 1ns/1ps
module march_tgen_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic a_start = 0, a_mode = 0, b_start = 0, b_mode = 0;
   logic [3:0] a_addr; logic [7:0] a_wd, a_ed; logic a_we, a_re, a_ev, a_dn;
   logic [2:0] b_addr; logic [0:0] b_wd, b_ed; logic b_we, b_re, b_ev, b_dn;

   march_tgen #(.ADDR_W(4), .DATA_W(8), .RD_LAT(1)) u_march_tgen (
      .clk(clk), .rst_n(rst_n), .start(a_start), .mode(a_mode),
      .mem_addr(a_addr), .mem_we(a_we), .mem_re(a_re), .mem_wdata(a_wd),
      .exp_data(a_ed), .exp_valid(a_ev), .done(a_dn));

   march_tgen #(.ADDR_W(3), .DATA_W(1), .RD_LAT(2)) u_march_tgen_b (
      .clk(clk), .rst_n(rst_n), .start(b_start), .mode(b_mode),
      .mem_addr(b_addr), .mem_we(b_we), .mem_re(b_re), .mem_wdata(b_wd),
      .exp_data(b_ed), .exp_valid(b_ev), .done(b_dn));

   int n_chk = 0, n_bad = 0;
   typedef struct {bit we; int addr; int data;} op_t;
   op_t ops[$];

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // operation list built from pass descriptions
   task automatic build(int alg, int aw, int dw);
      string p[$]; string dir; int nbg, n;
      ops.delete();
      n = 1 << aw;
      if (alg == 0) begin p = '{"w0", "r0w1", "r1w0"}; dir = "UUD"; nbg = 1; end
      else begin
         p = '{"w0", "r0w1", "r1w0r0r0w1", "r1w0", "r0w1r1r1w0", "r0"}; dir = "UDUUUU";
         nbg = (dw == 1) ? 1 : $clog2(dw) + 1;
      end
      for (int k = 0; k < nbg; k++) begin
         int bg = 0;
         for (int i = 0; i < dw; i++)
            if (k > 0 && ((i >> (k - 1)) & 1)) bg |= (1 << i);
         for (int e = 0; e < p.size(); e++)
            for (int j = 0; j < n; j++) begin
               int ad = (dir[e] == "D") ? (n - 1 - j) : j;
               for (int c = 0; c < p[e].len(); c += 2) begin
                  op_t o;
                  o.we = (p[e][c] == "w");
                  o.addr = ad;
                  o.data = (p[e][c+1] == "1") ? (~bg & ((1 << dw) - 1)) : bg;
                  ops.push_back(o);
               end
            end
      end
   endtask

   task automatic set_start(int sel, bit s, bit m);
      if (sel == 0) begin a_start = s; a_mode = m; end
      else begin b_start = s; b_mode = m; end
   endtask

   task automatic run_case(int sel, int alg, int aw, int dw, int lat, int inject);
      int total;
      string rq;
      build(alg, aw, dw);
      total = ops.size();
      rq = (alg == 0) ? "R1" : "R2";
      check(total == ((alg == 0) ? 5 : 16) * (1 << aw) * ((alg == 1 && dw > 1) ? $clog2(dw) + 1 : 1),
            "R3", "op count", total, total);
      @(negedge clk);
      set_start(sel, 1, alg[0]);
      @(negedge clk);
      for (int c = 0; c <= total + lat + 3; c++) begin
         bit we, re, ev, dn; int ad, wd, ed;
         bit xwe, xre, xev, xdn; int xad, xwd, xed;
         we = sel ? b_we : a_we; re = sel ? b_re : a_re;
         ev = sel ? b_ev : a_ev; dn = sel ? b_dn : a_dn;
         ad = sel ? int'(b_addr) : int'(a_addr);
         wd = sel ? int'(b_wd) : int'(a_wd);
         ed = sel ? int'(b_ed) : int'(a_ed);
         xwe = (c < total) && ops[c].we;
         xre = (c < total) && !ops[c].we;
         xad = (c < total) ? ops[c].addr : 0;
         xwd = xwe ? ops[c].data : 0;
         xev = (c >= lat) && (c - lat < total) && !ops[c - lat].we;
         xed = xev ? ops[c - lat].data : 0;
         xdn = (c == total + lat);
         check(!(we && re), "R8", "we and re both high", int'(we), 0);
         check(we == xwe && re == xre, (c == inject + 1) ? "R6" : rq, "we/re",
               int'({we, re}), int'({xwe, xre}));
         check(ad == xad, "R9", "mem_addr", ad, xad);
         check(wd == xwd, (alg == 1) ? "R3" : "R1", "mem_wdata", wd, xwd);
         check(ev == xev && ed == xed, "R4", "exp_valid/exp_data",
               int'(ev) * 256 + ed, int'(xev) * 256 + xed);
         check(dn == xdn, "R5", "done", int'(dn), int'(xdn));
         set_start(sel, c == inject, (c == inject) ? !alg[0] : alg[0]);
         @(negedge clk);
      end
      set_start(sel, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check({a_we, a_re, a_ev, a_dn, a_addr, a_wd, a_ed} == '0, "R7", "outputs in reset", 1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({a_we, a_re, a_ev, a_dn, a_addr, a_wd, a_ed} == '0 &&
            {b_we, b_re, b_ev, b_dn, b_addr, b_wd, b_ed} == '0, "R7", "outputs after reset", 1, 0);
      run_case(0, 0, 4, 8, 1, -1);   // decoder test, wide word
      run_case(0, 1, 4, 8, 1, 37);   // cell test with backgrounds, start injected mid-run
      run_case(0, 0, 4, 8, 1, 20);   // decoder test, start injected
      run_case(1, 0, 3, 1, 2, -1);   // one-bit word, latency 2
      run_case(1, 1, 3, 1, 2, 50);   // one-bit cell test, no backgrounds
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule